// File: doc/BRIEF.md
# Byte-Buffered 16-bit Register Access Port

This block lets an 8-bit processor bus reach two 16-bit quantities: a live counter value that some other logic produces, and a 16-bit preload register kept inside this block. An 8-bit bus cannot move 16 bits at once, so a shared low-byte buffer keeps each 16-bit transfer atomic. A read of the counter's high byte captures the counter's low byte in that same cycle. A later read of the counter low address then returns the captured byte, not the live one. For writes, the low byte is written first and is only buffered. Writing the high byte then commits all 16 bits to the preload register in a single cycle.

While the counter is running, the block refuses every access. A refused write changes nothing. A refused read returns zero. When a read strobe and a write strobe arrive in the same cycle, the write is performed and the read is dropped. The read data output is registered and holds its value until the next accepted or refused read.

Top module: `bytebuf_access_port`

## Requirements
- R1: A synchronous active-high reset clears the low-byte buffer, the preload register (`reload_value`) and `rd_data` to zero.
- R2: With `run_active` low, a write to address 2 (preload low) stores `wr_data` in the low-byte buffer and leaves `reload_value` unchanged.
- R3: With `run_active` low, a write to address 3 (preload high) sets `reload_value` to {`wr_data`, buffer}, visible one clock later.
- R4: With `run_active` low, a read of address 1 (counter high) puts `cnt_value[15:8]` on `rd_data` one clock later, and in the same edge copies `cnt_value[7:0]` into the buffer.
- R5: With `run_active` low, a read of address 0 (counter low) returns the buffer contents, not the live counter low byte.
- R6: With `run_active` low, reads of address 2 and 3 return `reload_value[7:0]` and `reload_value[15:8]`. A read of address 2 leaves the buffer unchanged.
- R7: While `run_active` is high, writes to any address change neither the buffer nor `reload_value`.
- R8: While `run_active` is high, a read of any address sets `rd_data` to 00h and leaves the buffer unchanged.
- R9: When `wr_en` and `rd_en` are high in the same cycle, only the write takes effect, and `rd_data` keeps its previous value.
- R10: In a cycle with no read strobe, `rd_data` keeps its value.
- R11: Writes to address 0 or 1 (counter bytes) change neither the buffer nor `reload_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 2 | Byte address: 0 counter low, 1 counter high, 2 preload low, 3 preload high |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data byte |
| run_active | input | 1 | Counter running; blocks all accesses |
| cnt_value | input | 16 | Live counter snapshot |
| reload_value | output | 16 | Preload register contents |

## Verification
The bench runs directed sequences first. One writes low then high and checks that the 16-bit preload changes only on the high write. Another reads the counter high byte and then changes the counter value before reading the low byte, which shows whether the low read comes from the buffer or from the live input. A constrained-random phase then mixes every address with write-only, read-only, both-strobe and idle cycles, with the run flag high about a quarter of the time and the counter value changing every cycle. This separates blocking, write priority and read-data hold from the normal paths. Each cycle is compared against a bench model of the buffer, the preload and the read data.

// File: rtl/bbap_pkg.sv
package bbap_pkg;
  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_PRE_LO = 2'd2,
    SEL_PRE_HI = 2'd3
  } sel_e;
endpackage

// File: rtl/bbap_decode.sv
module bbap_decode
  import bbap_pkg::*;
(
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       run_active,
  input  logic [1:0] acc_addr,
  output logic       pre_lo_wr,
  output logic       pre_hi_wr,
  output logic       cnt_hi_rd,
  output logic       rd_take,
  output logic       rd_blocked,
  output sel_e       rd_sel
);
  logic wr_ok;
  logic rd_req;

  always_comb begin
    rd_sel     = sel_e'(acc_addr);
    wr_ok      = wr_en && !run_active;
    rd_req     = rd_en && !wr_en;          // write wins over a same-cycle read
    pre_lo_wr  = wr_ok && (rd_sel == SEL_PRE_LO);
    pre_hi_wr  = wr_ok && (rd_sel == SEL_PRE_HI);
    rd_take    = rd_req && !run_active;
    rd_blocked = rd_req && run_active;
    cnt_hi_rd  = rd_take && (rd_sel == SEL_CNT_HI);
  end
endmodule

// File: rtl/bbap_store.sv
module bbap_store #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_lo_wr,
  input  logic              pre_hi_wr,
  input  logic              cnt_hi_rd,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] buf_q,
  output logic [WORD_W-1:0] pre_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      pre_q <= '0;
    end else begin
      if (pre_lo_wr)      buf_q <= wr_data;
      else if (cnt_hi_rd) buf_q <= cnt_lo;
      if (pre_hi_wr)      pre_q <= {wr_data, buf_q};
    end
  end

  p_lo_wr_keeps_pre_r2: assert property (@(posedge clk) disable iff (rst)
    pre_lo_wr |=> $stable(pre_q));
  p_hi_wr_commit_r3: assert property (@(posedge clk) disable iff (rst)
    pre_hi_wr |=> pre_q == {$past(wr_data), $past(buf_q)});
  p_cnt_hi_capture_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_hi_rd |=> buf_q == $past(cnt_lo));
endmodule

// File: rtl/bbap_readback.sv
module bbap_readback
  import bbap_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_take,
  input  logic              rd_blocked,
  input  sel_e              rd_sel,
  input  logic [BYTE_W-1:0] buf_q,
  input  logic [BYTE_W-1:0] cnt_hi,
  input  logic [WORD_W-1:0] pre_q,
  output logic [BYTE_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst || rd_blocked) begin
      rd_data <= '0;
    end else if (rd_take) begin
      case (rd_sel)
        SEL_CNT_LO: rd_data <= buf_q;
        SEL_CNT_HI: rd_data <= cnt_hi;
        SEL_PRE_LO: rd_data <= pre_q[BYTE_W-1:0];
        default:    rd_data <= pre_q[WORD_W-1:BYTE_W];
      endcase
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!rd_take && !rd_blocked) |=> $stable(rd_data));
  p_blocked_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rd_blocked |=> rd_data == '0);
  p_cnt_lo_buf_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_take && rd_sel == SEL_CNT_LO) |=> rd_data == $past(buf_q));
endmodule

// File: rtl/bytebuf_access_port.sv
module bytebuf_access_port
  import bbap_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        acc_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              run_active,
  input  logic [WORD_W-1:0] cnt_value,
  output logic [WORD_W-1:0] reload_value
);
  logic              pre_lo_wr, pre_hi_wr, cnt_hi_rd, rd_take, rd_blocked;
  sel_e              rd_sel;
  logic [BYTE_W-1:0] buf_q;

  bbap_decode u_decode (
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .run_active (run_active),
    .acc_addr   (acc_addr),
    .pre_lo_wr  (pre_lo_wr),
    .pre_hi_wr  (pre_hi_wr),
    .cnt_hi_rd  (cnt_hi_rd),
    .rd_take    (rd_take),
    .rd_blocked (rd_blocked),
    .rd_sel     (rd_sel)
  );

  bbap_store #(.BYTE_W(BYTE_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .pre_lo_wr (pre_lo_wr),
    .pre_hi_wr (pre_hi_wr),
    .cnt_hi_rd (cnt_hi_rd),
    .wr_data   (wr_data),
    .cnt_lo    (cnt_value[BYTE_W-1:0]),
    .buf_q     (buf_q),
    .pre_q     (reload_value)
  );

  bbap_readback #(.BYTE_W(BYTE_W)) u_readback (
    .clk        (clk),
    .rst        (rst),
    .rd_take    (rd_take),
    .rd_blocked (rd_blocked),
    .rd_sel     (rd_sel),
    .buf_q      (buf_q),
    .cnt_hi     (cnt_value[WORD_W-1:BYTE_W]),
    .pre_q      (reload_value),
    .rd_data    (rd_data)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && reload_value == '0));
  p_run_freezes_r7: assert property (@(posedge clk) disable iff (rst)
    (run_active && !rd_en) |=> $stable(reload_value) && $stable(buf_q));
  p_run_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (run_active && rd_en && !wr_en) |=> rd_data == '0);
  p_cnt_hi_read_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_active && rd_en && !wr_en && acc_addr == 2'd1) |=> rd_data == $past(cnt_value[WORD_W-1:BYTE_W]));
  p_wr_priority_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> $stable(rd_data));
  p_cnt_wr_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !acc_addr[1]) |=> $stable(reload_value) && $stable(buf_q));
endmodule

// File: tb/bytebuf_access_port_tb.sv
`timescale 1ns/1ps
module bytebuf_access_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  acc_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, run_active = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cnt_value = '0;
  logic [7:0]  rd_data;
  logic [15:0] reload_value;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0]  m_buf = '0;
  logic [15:0] m_pre = '0;
  logic [7:0]  m_rd  = '0;

  always #2.5 clk = ~clk;

  bytebuf_access_port u_dut (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .run_active(run_active),
    .cnt_value(cnt_value), .reload_value(reload_value)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic string op_tag(logic w, logic r, logic [1:0] a, logic run);
    if (w) return run ? "R7" : (r ? "R9" : (a == 2'd3 ? "R3" : (a == 2'd2 ? "R2" : "R11")));
    if (r) return run ? "R8" : (a == 2'd0 ? "R5" : (a == 2'd1 ? "R4" : "R6"));
    return "R10";
  endfunction

  // one bus cycle: drive at negedge, update model, compare at next negedge
  task automatic step(logic w, logic r, logic [1:0] a, logic [7:0] d, logic run, logic [15:0] cnt);
    string tag;
    wr_en = w; rd_en = r; acc_addr = a; wr_data = d; run_active = run; cnt_value = cnt;
    tag = op_tag(w, r, a, run);
    if (w) begin
      if (!run) begin
        if (a == 2'd2) m_buf = d;
        else if (a == 2'd3) m_pre = {d, m_buf};
      end
    end else if (r) begin
      if (run) m_rd = 8'h00;
      else case (a)
        2'd0: m_rd = m_buf;
        2'd1: begin m_rd = cnt[15:8]; m_buf = cnt[7:0]; end
        2'd2: m_rd = m_pre[7:0];
        default: m_rd = m_pre[15:8];
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(tag, {8'h00, rd_data}, {8'h00, m_rd});
    check(tag, reload_value, m_pre);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ACE));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, buffer seen through a counter-low read
    check("R1", {8'h00, rd_data}, 16'h0000);
    check("R1", reload_value, 16'h0000);
    step(1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 16'hFFFF);
    // R2 then R3: low write buffers only, high write commits 16 bits
    step(1'b1, 1'b0, 2'd2, 8'hAB, 1'b0, 16'h0);
    step(1'b1, 1'b0, 2'd3, 8'hCD, 1'b0, 16'h0);
    // R6: read both preload bytes; low read leaves buffer
    step(1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 16'h0);
    step(1'b0, 1'b1, 2'd3, 8'h00, 1'b0, 16'h0);
    step(1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 16'h0);
    // R4/R5: capture low byte, then counter changes before low read
    step(1'b0, 1'b1, 2'd1, 8'h00, 1'b0, 16'h1234);
    step(1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 16'h5678);
    // R7/R8: run blocks writes and reads
    step(1'b1, 1'b0, 2'd3, 8'h99, 1'b1, 16'h0);
    step(1'b1, 1'b0, 2'd2, 8'h77, 1'b1, 16'h0);
    step(1'b0, 1'b1, 2'd1, 8'h00, 1'b1, 16'hBEEF);
    step(1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 16'h0);
    // R9: both strobes, write wins, rd_data holds
    step(1'b1, 1'b1, 2'd3, 8'h5A, 1'b0, 16'h0);
    // R11: counter-address writes ignored; R10 idle hold
    step(1'b1, 1'b0, 2'd0, 8'h11, 1'b0, 16'h0);
    step(1'b1, 1'b0, 2'd1, 8'h22, 1'b0, 16'h0);
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 16'h0);
    step(1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 16'h0);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      int unsigned k;
      logic w, r;
      k = $urandom % 8;
      w = (k < 3) || (k == 6);
      r = (k >= 3 && k < 6) || (k == 6);
      step(w, r, 2'($urandom % 4), 8'($urandom), ($urandom % 4) == 0, 16'($urandom));
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule